// File: doc/BRIEF.md
# CRC-Gated Convolutional Decode Dispatcher

This block sits at the front of a receiver for frames built from rate-1/2 convolutional code bits followed by a 32-bit CRC. The CRC covers those coded bits. Frame bits arrive serially, one per cycle when `bit_valid` is high. The block runs the CRC over every arriving bit and keeps the coded bits in a frame buffer. Once the whole frame is in, it knows whether the frame arrived intact, and no decoding has been done yet.

If the frame is intact, the block recovers the message without a trellis search. It walks the coded pairs through a table indexed by encoder state and received pair, which gives the input bit and the next state directly. It then presents the whole message word together with a one-cycle completion pulse.

If the CRC does not come out clean, the block raises a one-cycle request and replays the buffered coded pairs to an external Viterbi decoder over a valid/ready handshake. It does the same if the table walk meets a pair that no branch of the current state could have produced.

Top module: `crc_gate_dispatch`

## Requirements
- R1: After reset, `done`, `vit_req` and `vit_valid` are low, and `lut_err` is low.
- R2: A frame is 2*MSG_BITS coded bits followed by 32 check bits, with the highest check bit sent first. The check register starts at all ones and shifts in each bit with the highest bit first, using polynomial 0x04C11DB7. The frame passes only if the register is all zeros after the last check bit.
- R3: On a passing frame, the table walk starts in state 0. Encoder state bit 1 is the newest input and bit 0 the one before it. For input u, the first coded bit is the parity of {u,state} masked by G_FIRST and the second is the parity masked by G_SECOND; the next state is {u, state[1]}. At `done`, `msg_out[k]` holds message bit k (bit 0 sent first) and `path_vit` is 0.
- R4: On a passing, consistent frame, `done` is high in the cycle that follows the (MSG_BITS+1)-th clock edge after the edge that accepts the last frame bit.
- R5: On a failing CRC, `vit_req` pulses for one cycle, in the cycle right after the edge that accepts the last frame bit. The pairs then go out in arrival order on `vit_pair`, with `vit_pair[1]` the first coded bit of the pair.
- R6: While `vit_valid` is high and `vit_ready` is low, `vit_valid`, `vit_pair` and `vit_last` hold their values. `vit_last` is high on exactly the final pair.
- R7: On the Viterbi path, `done` is high in the cycle after the handshake of the final pair, with `path_vit` at 1. `msg_out` keeps its previous value.
- R8: If the CRC passes but pair j does not match either branch of the current state, `lut_err` is 1 at `done`, `vit_req` pulses j+2 cycles after the last bit is accepted, and all pairs are forwarded starting from pair 0.
- R9: `bit_valid` is ignored outside frame reception, and the next frame is counted from its first bit.
- R10: `done` is high for exactly one cycle per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Frame bit strobe |
| bit_in | input | 1 | Serial frame bit |
| vit_ready | input | 1 | Viterbi decoder accepts the current pair |
| vit_req | output | 1 | One-cycle request to start the Viterbi path |
| vit_valid | output | 1 | A coded pair is being offered |
| vit_pair | output | 2 | Offered pair, [1] = first coded bit |
| vit_last | output | 1 | Offered pair is the final one |
| done | output | 1 | One-cycle frame completion |
| path_vit | output | 1 | 1 = frame went to the Viterbi path |
| lut_err | output | 1 | CRC passed but the table walk hit an impossible pair |
| msg_out | output | MSG_BITS | Decoded message from the table path |

## Verification
The hardest case to reach is a frame whose checksum is correct but whose coded stream no encoder could have produced. Random channel errors almost never cause it, because they break the CRC first. The stimulus builds this case on purpose: it flips one bit of a chosen pair and then recomputes the checksum over the damaged stream. The table walk therefore fails in a known cycle, which pins down both the request cycle and the `lut_err` flag. Forwarding is also tested with a ready signal that stalls, while stray input strobes arrive during the replay.

// File: rtl/crcgate_pkg.sv
package crcgate_pkg;

  localparam int CRC_W = 32;

  typedef enum logic [2:0] {
    ST_RECV  = 3'd0,
    ST_CHECK = 3'd1,
    ST_LUT   = 3'd2,
    ST_FWD   = 3'd3,
    ST_DONE  = 3'd4
  } gate_st_e;

  // One serial CRC step, highest bit first.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] r,
                                                input logic b,
                                                input logic [CRC_W-1:0] poly);
    logic fb;
    fb = r[CRC_W-1] ^ b;
    return {r[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction

  // Encoder output pair for state st and input u: [1] first coded bit.
  function automatic logic [1:0] conv_pair(input logic [1:0] st, input logic u,
                                           input logic [2:0] ga, input logic [2:0] gb);
    logic [2:0] win;
    win = {u, st};
    return {^(win & ga), ^(win & gb)};
  endfunction

  function automatic logic [1:0] conv_next(input logic [1:0] st, input logic u);
    return {u, st[1]};
  endfunction

endpackage

// File: rtl/crcgate_crc.sv
module crcgate_crc #(
  parameter logic [31:0] POLY = 32'h04C11DB7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic        din,
  output logic        zero
);
  import crcgate_pkg::*;

  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) crc_q <= '1;
    else if (en)       crc_q <= crc_step(crc_q, din, POLY);
  end

  assign zero = (crc_q == '0);

  assert_crc_preset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !zero);

endmodule

// File: rtl/crcgate_lut.sv
module crcgate_lut #(
  parameter logic [2:0] GA = 3'b111,
  parameter logic [2:0] GB = 3'b101
) (
  input  logic [1:0] st,
  input  logic [1:0] pair,
  output logic       hit,
  output logic       u,
  output logic [1:0] nst
);
  import crcgate_pkg::*;

  localparam int NSTATE = 4;

  logic [NSTATE-1:0] hit0, hit1;

  for (genvar s = 0; s < NSTATE; s++) begin : g_row
    localparam logic [1:0] P0 = conv_pair(2'(s), 1'b0, GA, GB);
    localparam logic [1:0] P1 = conv_pair(2'(s), 1'b1, GA, GB);
    assign hit0[s] = (pair == P0);
    assign hit1[s] = (pair == P1);
  end

  always_comb begin
    hit = hit0[st] | hit1[st];
    u   = hit1[st] & ~hit0[st];
    nst = conv_next(st, u);
  end

endmodule

// File: rtl/crc_gate_dispatch.sv
module crc_gate_dispatch #(
  parameter int          MSG_BITS = 16,
  parameter logic [2:0]  G_FIRST  = 3'b111,
  parameter logic [2:0]  G_SECOND = 3'b101,
  parameter logic [31:0] CRC_POLY = 32'h04C11DB7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_valid,
  input  logic                bit_in,
  input  logic                vit_ready,
  output logic                vit_req,
  output logic                vit_valid,
  output logic [1:0]          vit_pair,
  output logic                vit_last,
  output logic                done,
  output logic                path_vit,
  output logic                lut_err,
  output logic [MSG_BITS-1:0] msg_out
);
  import crcgate_pkg::*;

  localparam int CODED = 2 * MSG_BITS;
  localparam int TOTAL = CODED + CRC_W;
  localparam int CW    = $clog2(TOTAL);
  localparam int PW    = $clog2(MSG_BITS + 1);
  localparam logic [CW-1:0] LAST_BIT  = CW'(TOTAL - 1);
  localparam logic [PW-1:0] LAST_PAIR = PW'(MSG_BITS - 1);

  gate_st_e st_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] pidx_q;
  logic [MSG_BITS-1:0] c0_q, c1_q, work_q, work_nx, msg_q;
  logic [1:0] lstate_q, cur_pair, lut_nst;
  logic lut_hit, lut_u, path_q, lerr_q;
  logic take_bit, crc_zero, crc_clr;

  // Named events for the checks
  logic crc_pass_evt, crc_fail_evt, lut_miss_evt, fwd_hs_evt;

  assign take_bit = (st_q == ST_RECV) && bit_valid;
  assign crc_clr  = (st_q == ST_DONE);

  crcgate_crc #(.POLY(CRC_POLY)) i_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(take_bit), .din(bit_in),
    .zero(crc_zero)
  );

  assign cur_pair = {c0_q[pidx_q], c1_q[pidx_q]};

  crcgate_lut #(.GA(G_FIRST), .GB(G_SECOND)) i_lut (
    .st(lstate_q), .pair(cur_pair), .hit(lut_hit), .u(lut_u), .nst(lut_nst)
  );

  always_comb begin
    work_nx = work_q;
    work_nx[pidx_q] = lut_u;
  end

  assign crc_pass_evt = (st_q == ST_CHECK) &&  crc_zero;
  assign crc_fail_evt = (st_q == ST_CHECK) && !crc_zero;
  assign lut_miss_evt = (st_q == ST_LUT)   && !lut_hit;
  assign fwd_hs_evt   = (st_q == ST_FWD)   && vit_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_RECV;
      cnt_q    <= '0;
      pidx_q   <= '0;
      c0_q     <= '0;
      c1_q     <= '0;
      work_q   <= '0;
      msg_q    <= '0;
      lstate_q <= '0;
      path_q   <= 1'b0;
      lerr_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_RECV: if (bit_valid) begin
          if (cnt_q < CW'(CODED)) begin
            if (!cnt_q[0]) c0_q[cnt_q[CW-1:1]] <= bit_in;
            else           c1_q[cnt_q[CW-1:1]] <= bit_in;
          end
          if (cnt_q == LAST_BIT) begin
            cnt_q <= '0;
            st_q  <= ST_CHECK;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_CHECK: begin
          pidx_q   <= '0;
          lstate_q <= '0;
          lerr_q   <= 1'b0;
          st_q     <= crc_zero ? ST_LUT : ST_FWD;
        end
        ST_LUT: begin
          if (!lut_hit) begin
            lerr_q <= 1'b1;
            pidx_q <= '0;
            st_q   <= ST_FWD;
          end else begin
            work_q   <= work_nx;
            lstate_q <= lut_nst;
            if (pidx_q == LAST_PAIR) begin
              msg_q  <= work_nx;
              path_q <= 1'b0;
              st_q   <= ST_DONE;
            end else begin
              pidx_q <= pidx_q + 1'b1;
            end
          end
        end
        ST_FWD: if (vit_ready) begin
          if (pidx_q == LAST_PAIR) begin
            path_q <= 1'b1;
            st_q   <= ST_DONE;
          end else begin
            pidx_q <= pidx_q + 1'b1;
          end
        end
        ST_DONE: st_q <= ST_RECV;
        default: st_q <= ST_RECV;
      endcase
    end
  end

  assign vit_req   = crc_fail_evt || lut_miss_evt;
  assign vit_valid = (st_q == ST_FWD);
  assign vit_pair  = vit_valid ? cur_pair : 2'b00;
  assign vit_last  = vit_valid && (pidx_q == LAST_PAIR);
  assign done      = (st_q == ST_DONE);
  assign path_vit  = path_q;
  assign lut_err   = lerr_q;
  assign msg_out   = msg_q;

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_vit_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vit_valid && !vit_ready |=> vit_valid && $stable(vit_pair) && $stable(vit_last));

  assert_req_then_offer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vit_req |=> vit_valid && !vit_last || (vit_valid && MSG_BITS == 1));

  assert_pass_no_offer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    crc_pass_evt |=> !vit_valid);

  assert_lerr_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && lut_err |-> path_vit);

  assert_fwd_to_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hs_evt && vit_last |=> done && path_vit);

endmodule

// File: tb/test_crc_gate_dispatch.sv
module test_crc_gate_dispatch;
  localparam int N = 16;
  localparam int CODED = 2 * N;

  logic clk = 0, rst_n = 0, bit_valid = 0, bit_in = 0, vit_ready = 0;
  logic vit_req, vit_valid, vit_last, done, path_vit, lut_err;
  logic [1:0] vit_pair;
  logic [N-1:0] msg_out;

  crc_gate_dispatch #(.MSG_BITS(N)) i_crc_gate_dispatch (
    .clk, .rst_n, .bit_valid, .bit_in, .vit_ready, .vit_req, .vit_valid,
    .vit_pair, .vit_last, .done, .path_vit, .lut_err, .msg_out
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit timed_out = 0;

  // results of the last frame
  int done_cyc, req_cyc, req_cnt, npairs, hs_cyc, last_bad, hold_bad;
  logic [1:0] got_pairs [N];
  logic got_path, got_lerr;
  logic [N-1:0] got_msg;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [CODED-1:0] encode(input logic [N-1:0] m);
    logic s1 = 0, s0 = 0;
    logic [CODED-1:0] c;
    for (int k = 0; k < N; k++) begin
      c[2*k]   = m[k] ^ s1 ^ s0;  // taps 111
      c[2*k+1] = m[k] ^ s0;       // taps 101
      s0 = s1;
      s1 = m[k];
    end
    return c;
  endfunction

  function automatic logic [31:0] checksum(input logic [CODED-1:0] c);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int i = 0; i < CODED; i++) begin
      logic top = r[31] ^ c[i];
      r = r << 1;
      if (top) r = r ^ 32'h04C1_1DB7;
    end
    return r;
  endfunction

  task automatic run_frame(input logic [CODED-1:0] c, input logic [31:0] ck,
                           input bit stall, input bit inject);
    int cyc;
    logic [1:0] held;
    bit was_stall;
    for (int i = 0; i < CODED + 32; i++) begin
      @(negedge clk);
      bit_valid = 1;
      bit_in = (i < CODED) ? c[i] : ck[31 - (i - CODED)];
    end
    done_cyc = -1; req_cyc = -1; req_cnt = 0; npairs = 0; hs_cyc = -1;
    last_bad = 0; hold_bad = 0; was_stall = 0; held = 0;
    cyc = 0;
    while (cyc < 400) begin
      @(negedge clk);
      cyc++;
      bit_valid = 0;
      if (was_stall && (!vit_valid || vit_pair != held)) hold_bad++;
      was_stall = 0;
      if (vit_req) begin req_cnt++; if (req_cyc < 0) req_cyc = cyc; end
      if (done) begin
        done_cyc = cyc; got_path = path_vit; got_lerr = lut_err; got_msg = msg_out;
        break;
      end
      vit_ready = stall ? (cyc % 3 != 0) : 1'b1;
      if (vit_valid) begin
        if (vit_ready) begin
          if (npairs < N) got_pairs[npairs] = vit_pair;
          if (vit_last != (npairs == N - 1)) last_bad++;
          npairs++;
          hs_cyc = cyc;
        end else begin
          was_stall = 1;
          held = vit_pair;
        end
        if (inject) begin bit_valid = 1; bit_in = cyc[0]; end
      end
    end
    vit_ready = 0;
    bit_valid = 0;
    if (done_cyc < 0) begin
      timed_out = 1;
      chk(0, "watchdog", 0, 1);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!done && !vit_req && !vit_valid && !lut_err, "R1 reset outputs",
        {done, vit_req, vit_valid, lut_err}, 0);
  endtask

  task automatic t_bypass(input logic [N-1:0] m);
    logic [CODED-1:0] c = encode(m);
    run_frame(c, checksum(c), 0, 0);
    chk(got_path == 0, "R2 clean frame passes", got_path, 0);
    chk(got_msg == m, "R3 table decode", got_msg, m);
    chk(done_cyc == N + 2, "R4 bypass latency", done_cyc, N + 2);
    chk(req_cnt == 0 && npairs == 0, "R3 no request", req_cnt, 0);
  endtask

  task automatic t_fail(input logic [N-1:0] m, input int flip, input bit inject);
    logic [CODED-1:0] c = encode(m);
    logic [31:0] ck = checksum(c);
    logic [N-1:0] prev = msg_out;
    bit pairs_ok = 1;
    if (flip < CODED) c[flip] = ~c[flip]; else ck[flip - CODED] = ~ck[flip - CODED];
    run_frame(c, ck, 1, inject);
    chk(req_cnt == 1 && req_cyc == 1, "R5 request pulse", req_cyc, 1);
    for (int k = 0; k < N; k++) if (got_pairs[k] != {c[2*k], c[2*k+1]}) pairs_ok = 0;
    chk(npairs == N && pairs_ok, "R5 forwarded pairs", npairs, N);
    chk(last_bad == 0 && hold_bad == 0, "R6 last flag and hold", last_bad + hold_bad, 0);
    chk(got_path == 1 && done_cyc == hs_cyc + 1, "R7 viterbi done", done_cyc, hs_cyc + 1);
    chk(got_msg == prev, "R7 msg kept", got_msg, prev);
    chk(got_lerr == 0, "R8 no table error", got_lerr, 0);
  endtask

  task automatic t_inconsistent(input logic [N-1:0] m, input int j);
    logic [CODED-1:0] c = encode(m);
    bit pairs_ok = 1;
    c[2*j] = ~c[2*j];
    run_frame(c, checksum(c), 0, 0);
    chk(got_lerr == 1 && got_path == 1, "R8 table error flag", {got_lerr, got_path}, 3);
    chk(req_cyc == j + 2 && req_cnt == 1, "R8 request cycle", req_cyc, j + 2);
    for (int k = 0; k < N; k++) if (got_pairs[k] != {c[2*k], c[2*k+1]}) pairs_ok = 0;
    chk(npairs == N && pairs_ok, "R8 full replay", npairs, N);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_bypass(16'hA5C3);
    t_bypass(16'h0000);
    t_bypass(16'hFFFF);
    t_fail(16'h3C96, 7, 0);
    t_fail(16'h1234, CODED + 5, 0);
    t_inconsistent(16'hBEEF, 3);
    t_bypass(16'h5A0F);
    chk(got_lerr == 0, "R8 flag cleared", got_lerr, 0);
    t_fail(16'h0F0F, 20, 1);
    t_bypass(16'h9C31);  // R9 stray strobes during replay must not shift this frame
    chk(got_msg == 16'h9C31, "R9 stray bits ignored", got_msg, 16'h9C31);
    @(negedge clk);
    chk(!done, "R10 done single cycle", done, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule